// File: doc/BRIEF.md
# SD Command Issue Encoder

This block sits between a host controller's command sequencer and the logic that shifts commands onto the card's command wire. A request carries a 6-bit command index, a 32-bit argument, a flag marking the index as an application-specific command (one that follows the application-command prefix), a flag saying whether the attached card is an MMC card rather than an SD card, and a flag saying whether the host can move data by DMA. From these the block builds a 32-bit transfer control word: response kind, CRC and index check enables, data-present and direction, block-count enable, DMA enable and the index itself.

A request is accepted only while the block is idle. It first pulses a clear for pending interrupt status, then waits until both the command-inhibit and data-inhibit inputs are low. Once they are, it strobes the latched argument and, one cycle later, the transfer word, which acts as the start strobe for the serializer. If the lines stay occupied for `TIMEOUT_CYC` waiting cycles, the request is dropped with a busy-error pulse. A request made while a command is still in flight is refused with a reject pulse, and the command in flight is left as it was.

Top module: `sd_cmd_issue`

## Requirements
- R1: The response kind sits in `xfer_o[17:16]`: 00 for no response (index 0), 01 for the 136-bit response (indices 2 and 9), 11 for the 48-bit response with busy (index 7, and index 6 on an MMC card), and 10 for every other plain index.
- R2: CRC check (`xfer_o[19]`) and index check (`xfer_o[20]`) are both set for every plain index except 0, 1, 2 and 9. Indices 2 and 9 set only the CRC check, and indices 0 and 1 set neither.
- R3: Data present (`xfer_o[21]`) is set for plain indices 17, 18 and 24, and for index 6 on an SD card. Read direction (`xfer_o[4]` = 1) applies to all of these except 24, which is a write (`xfer_o[4]` = 0).
- R4: On an MMC card, plain indices 8 and 14 are reads with data present and index 19 is a write with data present. On an SD card these three indices carry no data.
- R5: Block-count enable (`xfer_o[1]`) is set only for plain index 18. DMA enable (`xfer_o[0]`) is set for plain indices 17, 18 and 24 only while the DMA-capable flag is high.
- R6: With the application flag high, every index gets the 48-bit response with both checks and no data. The exceptions are index 41, which clears both checks, and index 51, which adds a data read. Block count and DMA stay off.
- R7: The command index appears in `xfer_o[29:24]`. Every bit not named in R1 to R6 is zero.
- R8: After an accepted start, `irq_clr_o` pulses in the next cycle. The block then waits until both inhibit inputs are low, pulses `arg_we_o` with `arg_o` holding the request's argument, and pulses `xfer_we_o` in the following cycle, after which it is idle again.
- R9: If the inhibit lines are occupied for `TIMEOUT_CYC` consecutive waiting cycles, `busy_err_o` pulses once, neither write strobe fires, and the block returns to idle.
- R10: A start while `busy_o` is high produces a one-cycle `reject_o` in the following cycle. The in-flight command's argument and transfer word remain unchanged and are still launched.
- R11: After reset all pulse outputs and `busy_o` are low, and `arg_o` and `xfer_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to issue a command |
| cmd_idx_i | input | 6 | Command index |
| app_cmd_i | input | 1 | Index is an application-specific command |
| card_mmc_i | input | 1 | Attached card is MMC (0 = SD) |
| dma_cap_i | input | 1 | Host supports DMA transfers |
| arg_i | input | 32 | Command argument |
| cmd_inhibit_i | input | 1 | Command line occupied |
| dat_inhibit_i | input | 1 | Data line occupied |
| irq_clr_o | output | 1 | Pulse clearing pending interrupt status |
| arg_we_o | output | 1 | Argument write strobe |
| arg_o | output | 32 | Latched argument |
| xfer_we_o | output | 1 | Transfer word write strobe, starts the command |
| xfer_o | output | 32 | Latched transfer control word |
| busy_o | output | 1 | A command is in flight |
| busy_err_o | output | 1 | Lines stayed occupied past the timeout |
| reject_o | output | 1 | Start refused because the block was busy |

## Verification
The encoder is swept over all 64 indices crossed with the application flag, card type and DMA capability. This separates the plain rules from the application exceptions, the SD cases from the MMC cases for indices 6, 8, 14 and 19, and the DMA-gated bits from the ones that do not depend on DMA. Launch timing is tried with the lines idle from the start, released after a short wait, released on the last waiting cycle before the timeout, and released one cycle too late, so that the boundary between a late launch and a busy error is resolved to a single cycle. A second start during a held-off command checks that the reject pulse appears and that the first command's word still launches unchanged.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_136  = 2'b01,
    RSP_48   = 2'b10,
    RSP_48B  = 2'b11
  } rsp_e;

  typedef struct packed {
    rsp_e rsp;
    logic crc_chk;
    logic idx_chk;
    logic dat_pres;
    logic dat_rd;
    logic blk_cnt_en;
    logic dma_en;
  } xfer_ctl_t;

  localparam int IDX_LSB    = 24;
  localparam int RSP_LSB    = 16;
  localparam int CRC_BIT    = 19;
  localparam int IDXCHK_BIT = 20;
  localparam int DATA_BIT   = 21;
  localparam int DIR_BIT    = 4;
  localparam int BCEN_BIT   = 1;
  localparam int DMA_BIT    = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_WAIT,
    ST_ARG,
    ST_XFER
  } st_e;

endpackage

// File: rtl/sd_cmd_encoder.sv
module sd_cmd_encoder
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              app_i,
  input  logic              mmc_i,
  input  logic              dma_i,
  output logic [WORD_W-1:0] word_o
);

  xfer_ctl_t ctl;
  int        i;

  always_comb begin
    ctl = '0;
    ctl.rsp = RSP_48;
    i = int'(idx_i);
    if (app_i) begin
      ctl.crc_chk = (i != 41);
      ctl.idx_chk = (i != 41);
      if (i == 51) begin
        ctl.dat_pres = 1'b1;
        ctl.dat_rd   = 1'b1;
      end
    end else begin
      case (i)
        0:       ctl.rsp = RSP_NONE;
        2, 9:    ctl.rsp = RSP_136;
        7:       ctl.rsp = RSP_48B;
        6:       ctl.rsp = mmc_i ? RSP_48B : RSP_48;
        default: ctl.rsp = RSP_48;
      endcase
      ctl.crc_chk = !(i == 0 || i == 1);
      ctl.idx_chk = ctl.crc_chk && !(i == 2 || i == 9);
      case (i)
        17, 18: begin
          ctl.dat_pres = 1'b1;
          ctl.dat_rd   = 1'b1;
        end
        24: ctl.dat_pres = 1'b1;
        6: begin
          ctl.dat_pres = !mmc_i;
          ctl.dat_rd   = !mmc_i;
        end
        8, 14: begin
          ctl.dat_pres = mmc_i;
          ctl.dat_rd   = mmc_i;
        end
        19: ctl.dat_pres = mmc_i;
        default: ;
      endcase
      ctl.blk_cnt_en = (i == 18);
      ctl.dma_en     = dma_i && (i == 17 || i == 18 || i == 24);
    end
  end

  always_comb begin
    word_o = '0;
    word_o[IDX_LSB +: IDX_W] = idx_i;
    word_o[RSP_LSB +: 2]     = ctl.rsp;
    word_o[CRC_BIT]          = ctl.crc_chk;
    word_o[IDXCHK_BIT]       = ctl.idx_chk;
    word_o[DATA_BIT]         = ctl.dat_pres;
    word_o[DIR_BIT]          = ctl.dat_rd;
    word_o[BCEN_BIT]         = ctl.blk_cnt_en;
    word_o[DMA_BIT]          = ctl.dma_en;
  end

  // R3
  always_comb begin
    dir_needs_data_chk: assert (!(word_o[DIR_BIT] && !word_o[DATA_BIT]));
  end

  // R2
  always_comb begin
    idx_chk_needs_crc_chk: assert (!(word_o[IDXCHK_BIT] && !word_o[CRC_BIT]));
  end

endmodule

// File: rtl/sd_line_wait.sv
module sd_line_wait #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic lines_busy_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!wait_i)               cnt_q <= '0;
    else if (lines_busy_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = wait_i && lines_busy_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  // R9
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TIMEOUT_CYC));

endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int WORD_W      = 32,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic              app_cmd_i,
  input  logic              card_mmc_i,
  input  logic              dma_cap_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic              cmd_inhibit_i,
  input  logic              dat_inhibit_i,
  output logic              irq_clr_o,
  output logic              arg_we_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic              xfer_we_o,
  output logic [WORD_W-1:0] xfer_o,
  output logic              busy_o,
  output logic              busy_err_o,
  output logic              reject_o
);

  st_e               st_q;
  logic [ARG_W-1:0]  arg_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              err_q;
  logic              rej_q;
  logic              lines_busy;
  logic              expired;

  assign lines_busy = cmd_inhibit_i | dat_inhibit_i;

  sd_cmd_encoder #(
    .IDX_W (IDX_W),
    .WORD_W(WORD_W)
  ) u_enc (
    .idx_i (cmd_idx_i),
    .app_i (app_cmd_i),
    .mmc_i (card_mmc_i),
    .dma_i (dma_cap_i),
    .word_o(word_d)
  );

  sd_line_wait #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wait_i      (st_q == ST_WAIT),
    .lines_busy_i(lines_busy),
    .expired_o   (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      arg_q  <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      rej_q <= start_i && (st_q != ST_IDLE);
      case (st_q)
        ST_IDLE: if (start_i) begin
          arg_q  <= arg_i;
          word_q <= word_d;
          st_q   <= ST_CLR;
        end
        ST_CLR:  st_q <= ST_WAIT;
        ST_WAIT: begin
          if (!lines_busy) st_q <= ST_ARG;
          else if (expired) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end
        end
        ST_ARG:  st_q <= ST_XFER;
        ST_XFER: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_clr_o  = (st_q == ST_CLR);
  assign arg_we_o   = (st_q == ST_ARG);
  assign xfer_we_o  = (st_q == ST_XFER);
  assign busy_o     = (st_q != ST_IDLE);
  assign busy_err_o = err_q;
  assign reject_o   = rej_q;
  assign arg_o      = arg_q;
  assign xfer_o     = word_q;

  // R8
  arg_before_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_we_o |-> $past(arg_we_o));

  // R8
  lines_idle_at_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arg_we_o |-> $past(!cmd_inhibit_i && !dat_inhibit_i));

  // R8
  clr_then_no_arg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> !arg_we_o);

  // R8
  pulses_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_clr_o, arg_we_o, xfer_we_o, busy_err_o}));

  // R9
  err_only_when_occupied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> $past(cmd_inhibit_i || dat_inhibit_i));

  // R10
  reject_only_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(start_i && busy_o));

  // R10
  inflight_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(xfer_o) && $stable(arg_o)));

endmodule

// File: tb/sd_cmd_issue_test.sv
module sd_cmd_issue_test;

  localparam int T = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic        app_cmd = 1'b0;
  logic        card_mmc = 1'b0;
  logic        dma_cap = 1'b0;
  logic [31:0] arg = '0;
  logic        cmd_inh = 1'b0;
  logic        dat_inh = 1'b0;
  logic        irq_clr, arg_we, xfer_we, busy, busy_err, reject;
  logic [31:0] arg_out, xfer_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_cmd_issue #(
    .TIMEOUT_CYC(T)
  ) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .cmd_idx_i    (cmd_idx),
    .app_cmd_i    (app_cmd),
    .card_mmc_i   (card_mmc),
    .dma_cap_i    (dma_cap),
    .arg_i        (arg),
    .cmd_inhibit_i(cmd_inh),
    .dat_inhibit_i(dat_inh),
    .irq_clr_o    (irq_clr),
    .arg_we_o     (arg_we),
    .arg_o        (arg_out),
    .xfer_we_o    (xfer_we),
    .xfer_o       (xfer_out),
    .busy_o       (busy),
    .busy_err_o   (busy_err),
    .reject_o     (reject)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int idx, input bit app, input bit mmc,
                                        input bit dma);
    int rsp, crc, ic, dp, rd, bc, dm;
    if (app) begin
      rsp = 2; crc = (idx != 41); ic = crc;
      dp = (idx == 51); rd = dp; bc = 0; dm = 0;
    end else begin
      if (idx == 2 || idx == 9) rsp = 1;
      else if (idx == 7 || (idx == 6 && mmc)) rsp = 3;
      else if (idx == 0) rsp = 0;
      else rsp = 2;
      crc = !(idx inside {0, 1});
      ic  = !(idx inside {0, 1, 2, 9});
      rd  = (idx inside {17, 18}) || (idx == 6 && !mmc) || (mmc && idx inside {8, 14});
      dp  = rd || idx == 24 || (mmc && idx == 19);
      bc  = (idx == 18);
      dm  = dma && (idx inside {17, 18, 24});
    end
    return 32'(idx * (1 << 24) + rsp * (1 << 16) + crc * (1 << 19) + ic * (1 << 20) +
               dp * (1 << 21) + rd * 16 + bc * 2 + dm);
  endfunction

  // rel: 0 = lines idle throughout, else negedge index at which inhibit drops
  task automatic run_cmd(input int idx, input bit app, input bit mmc, input bit dma,
                         input logic [31:0] a, input int rel, input string tag);
    int clr_n = 0, arg_n = 0, xfer_n = 0, err_n = 0;
    int exp_arg_n, exp_err_n;
    logic [31:0] w_at_arg = '0, a_at_arg = '0;
    logic [31:0] exp_w;
    @(negedge clk);
    cmd_idx = 6'(idx); app_cmd = app; card_mmc = mmc; dma_cap = dma; arg = a;
    start = 1'b1;
    cmd_inh = (rel != 0);
    dat_inh = (rel != 0) && idx[0];
    for (int n = 1; n <= T + 6; n++) begin
      @(negedge clk);
      if (n == 1) start = 1'b0;
      if (n == rel) begin cmd_inh = 1'b0; dat_inh = 1'b0; end
      if (irq_clr && clr_n == 0) clr_n = n;
      if (arg_we && arg_n == 0) begin arg_n = n; a_at_arg = arg_out; end
      if (xfer_we && xfer_n == 0) begin xfer_n = n; w_at_arg = xfer_out; end
      if (busy_err && err_n == 0) err_n = n;
    end
    cmd_inh = 1'b0; dat_inh = 1'b0;
    exp_arg_n = (rel <= T + 1) ? ((rel + 1 > 3) ? rel + 1 : 3) : 0;
    exp_err_n = (rel <= T + 1) ? 0 : T + 2;
    exp_w = model(idx, app, mmc, dma);
    check(clr_n == 1, "R8 clear pulse cycle", 32'(clr_n), 32'd1);
    check(arg_n == exp_arg_n, "R8 arg strobe cycle", 32'(arg_n), 32'(exp_arg_n));
    check(err_n == exp_err_n, "R9 busy error cycle", 32'(err_n), 32'(exp_err_n));
    if (exp_arg_n != 0) begin
      check(xfer_n == arg_n + 1, "R8 xfer strobe cycle", 32'(xfer_n), 32'(arg_n + 1));
      check(a_at_arg == a, "R8 argument", a_at_arg, a);
      check(w_at_arg == exp_w, tag, w_at_arg, exp_w);
    end else begin
      check(xfer_n == 0, "R9 no launch on timeout", 32'(xfer_n), 32'd0);
    end
    check(!busy, "R8 idle after command", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    check(!busy && !irq_clr && !arg_we && !xfer_we && !busy_err && !reject,
          "R11 pulses low in reset", {26'd0, busy, irq_clr, arg_we, xfer_we, busy_err, reject},
          32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(arg_out == 0 && xfer_out == 0, "R11 outputs zero", arg_out | xfer_out, 32'd0);

    // R1 R2 R3 R4 R5 R6 R7: full sweep
    for (int ap = 0; ap < 2; ap++)
      for (int mm = 0; mm < 2; mm++)
        for (int dm = 0; dm < 2; dm++)
          for (int ix = 0; ix < 64; ix++)
            run_cmd(ix, bit'(ap), bit'(mm), bit'(dm), 32'(ix * 32'h01010101 + ap * 7 + mm),
                    0, "R1 R2 R3 R4 R5 R6 R7 transfer word");

    // R8 R9 waiting and timeout boundary
    run_cmd(17, 1'b0, 1'b0, 1'b1, 32'hA5A5_0001, 2, "R8 word after short wait");
    run_cmd(24, 1'b0, 1'b0, 1'b1, 32'hA5A5_0002, 4, "R8 word after wait");
    run_cmd(19, 1'b0, 1'b1, 1'b0, 32'hA5A5_0003, T + 1, "R9 word on last wait cycle");
    run_cmd(18, 1'b0, 1'b0, 1'b1, 32'hA5A5_0004, T + 2, "R9 timeout");
    run_cmd(6, 1'b0, 1'b1, 1'b0, 32'hA5A5_0005, 99, "R9 never released");

    // R10: second start while held off
    begin
      logic [31:0] w17;
      int arg_seen = 0;
      w17 = model(17, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      cmd_idx = 6'd17; app_cmd = 1'b0; card_mmc = 1'b0; dma_cap = 1'b1;
      arg = 32'h1111_2222; start = 1'b1; cmd_inh = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      cmd_idx = 6'd24; arg = 32'h3333_4444; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(reject, "R10 reject pulse", 32'(reject), 32'd1);
      check(arg_out == 32'h1111_2222, "R10 argument kept", arg_out, 32'h1111_2222);
      check(xfer_out == w17, "R10 word kept", xfer_out, w17);
      @(negedge clk);
      check(!reject, "R10 reject one cycle", 32'(reject), 32'd0);
      cmd_inh = 1'b0;
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        if (xfer_we) begin
          arg_seen = 1;
          check(xfer_out == w17, "R10 first command launched", xfer_out, w17);
        end
      end
      check(arg_seen == 1, "R10 launch happened", 32'(arg_seen), 32'd1);
      check(!reject, "R10 no reject when idle", 32'(reject), 32'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule